// File: doc/BRIEF.md
# Congestion-Aware Minimal Output Port Selector

This block computes the output port for one packet per cycle inside a router of a two-dimensional mesh. It receives the signed distance still to travel along each axis, measured as destination coordinate minus current coordinate. From those distances it derives which of the five router outputs bring the packet closer to its target. The five outputs are the local ejection port and the positive and negative ports of each axis. When two outputs both make progress, it takes the one whose downstream queue holds fewer entries.

The choice is always minimal: a port that does not shorten the remaining path is never selected. A run-time mode adds a west-first turn restriction for deadlock freedom. In that mode a packet that still has negative-X distance to cover leaves on the negative-X port, whatever the queue occupancies are. The result is a one-hot port vector registered once, so the route is ready one clock after the request. Arbitration for the switch and credit tracking are done elsewhere; the queue occupancies arrive as plain inputs.

Top module: `adaptive_route_sel`

## Requirements
- R1: The selection vector `sel_dir` is 5 bits wide with bit 0 = local ejection (exit), bit 1 = +Y, bit 2 = +X, bit 3 = -Y, bit 4 = -X. Offsets `dx`, `dy` are signed two's complement values, and a positive offset means the destination lies in the + direction.
- R2: `sel_dir` is registered. It reflects the inputs sampled at the previous rising clock edge, and an active-low reset clears it to all zeros.
- R3: When `req_valid` was low at the sampling edge, `sel_dir` is all zeros.
- R4: When both offsets are zero, the only bit set is bit 0 (exit).
- R5: Only productive ports are chosen. A positive offset allows only the + port of its axis, a negative offset allows only the - port, and a zero offset allows neither port of that axis.
- R6: When both offsets are nonzero and the override of R8 does not apply, the productive port with the smaller queue length is chosen. The queue length used for each port is taken from its own 4-bit unsigned input.
- R7: When the two productive ports have equal queue lengths, the X-axis port is chosen.
- R8: With `west_first_en` high and `dx` negative, the selection is -X (bit 4) regardless of `dy` and of all queue lengths.
- R9: With `west_first_en` low, a negative `dx` combined with a nonzero `dy` is resolved by queue length, as in R6 and R7.
- R10: Whenever `req_valid` was high at the sampling edge, exactly one bit of `sel_dir` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A routing request is present this cycle |
| dx | input | OFS_W (4) | Signed X distance to destination |
| dy | input | OFS_W (4) | Signed Y distance to destination |
| west_first_en | input | 1 | Enables the west-first turn restriction |
| qlen_py | input | QLEN_W (4) | Occupancy of the queue behind the +Y port |
| qlen_px | input | QLEN_W (4) | Occupancy of the queue behind the +X port |
| qlen_my | input | QLEN_W (4) | Occupancy of the queue behind the -Y port |
| qlen_mx | input | QLEN_W (4) | Occupancy of the queue behind the -X port |
| sel_dir | output | 5 | One-hot selected output port, bit order as in R1 |

## Verification
The congestion comparison and the west-first override both act on the same request when `dx` is negative and `dy` is nonzero. To make them disagree, the bench loads the -X queue fuller than the productive Y queue. With the restriction on, the expected pick is -X despite the longer queue. With the restriction off, the identical offsets and occupancies must yield the Y port. Random requests that mix both modes with arbitrary occupancies repeat this collision often, and each result is judged against a behavioural model every cycle.

// File: rtl/arsel_pkg.sv
package arsel_pkg;
   localparam int unsigned DIR_N    = 5;
   localparam int unsigned DIR_EXIT = 0;
   localparam int unsigned DIR_PY   = 1;
   localparam int unsigned DIR_PX   = 2;
   localparam int unsigned DIR_MY   = 3;
   localparam int unsigned DIR_MX   = 4;

   typedef logic [DIR_N-1:0] dir_vec_t;

   localparam dir_vec_t EXIT_ONLY = dir_vec_t'(1) << DIR_EXIT;
   localparam dir_vec_t MX_ONLY   = dir_vec_t'(1) << DIR_MX;
   localparam dir_vec_t X_PORTS   = (dir_vec_t'(1) << DIR_PX) | (dir_vec_t'(1) << DIR_MX);
   localparam dir_vec_t Y_PORTS   = (dir_vec_t'(1) << DIR_PY) | (dir_vec_t'(1) << DIR_MY);
endpackage

// File: rtl/arsel_prod_mask.sv
module arsel_prod_mask
   import arsel_pkg::*;
#(
   parameter int unsigned OFS_W = 4
) (
   input  logic [OFS_W-1:0] dx,
   input  logic [OFS_W-1:0] dy,
   output dir_vec_t         mask
);
   localparam int unsigned AXES = 2;

   logic [AXES-1:0] nz;
   logic [AXES-1:0] neg;

   // axis 0 = X, axis 1 = Y
   for (genvar a = 0; a < AXES; a++) begin : g_axis
      logic [OFS_W-1:0] ofs;
      assign ofs    = (a == 0) ? dx : dy;
      assign nz[a]  = |ofs;
      assign neg[a] = ofs[OFS_W-1];
   end

   always_comb begin
      mask           = '0;
      mask[DIR_EXIT] = ~nz[0] & ~nz[1];
      mask[DIR_PX]   = nz[0] & ~neg[0];
      mask[DIR_MX]   = neg[0];
      mask[DIR_PY]   = nz[1] & ~neg[1];
      mask[DIR_MY]   = neg[1];
   end
endmodule

// File: rtl/arsel_pick.sv
module arsel_pick
   import arsel_pkg::*;
#(
   parameter int unsigned QLEN_W     = 4,
   parameter bit          TIE_X_WINS = 1'b1
) (
   input  dir_vec_t          mask,
   input  logic              wf_en,
   input  logic [QLEN_W-1:0] q_py,
   input  logic [QLEN_W-1:0] q_px,
   input  logic [QLEN_W-1:0] q_my,
   input  logic [QLEN_W-1:0] q_mx,
   output dir_vec_t          pick
);
   logic              has_x;
   logic              has_y;
   logic              x_wins;
   logic [QLEN_W-1:0] qx;
   logic [QLEN_W-1:0] qy;

   assign has_x = |(mask & X_PORTS);
   assign has_y = |(mask & Y_PORTS);
   assign qx    = mask[DIR_PX] ? q_px : q_mx;
   assign qy    = mask[DIR_PY] ? q_py : q_my;

   if (TIE_X_WINS) begin : g_tie_x
      assign x_wins = (qx <= qy);
   end else begin : g_tie_y
      assign x_wins = (qx < qy);
   end

   always_comb begin
      if (mask[DIR_EXIT]) begin
         pick = EXIT_ONLY;
      end else if (has_x && has_y) begin
         if (wf_en && mask[DIR_MX]) begin
            pick = MX_ONLY;
         end else begin
            pick = x_wins ? (mask & X_PORTS) : (mask & Y_PORTS);
         end
      end else begin
         pick = mask;
      end
   end
endmodule

// File: rtl/adaptive_route_sel.sv
module adaptive_route_sel
   import arsel_pkg::*;
#(
   parameter int unsigned OFS_W      = 4,
   parameter int unsigned QLEN_W     = 4,
   parameter bit          TIE_X_WINS = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic signed [OFS_W-1:0]  dx,
   input  logic signed [OFS_W-1:0]  dy,
   input  logic                     west_first_en,
   input  logic [QLEN_W-1:0]        qlen_py,
   input  logic [QLEN_W-1:0]        qlen_px,
   input  logic [QLEN_W-1:0]        qlen_my,
   input  logic [QLEN_W-1:0]        qlen_mx,
   output logic [4:0]               sel_dir
);
   if (OFS_W < 2) begin : g_bad_ofs
      $error("adaptive_route_sel: OFS_W must be at least 2");
   end
   if (QLEN_W < 1) begin : g_bad_qlen
      $error("adaptive_route_sel: QLEN_W must be at least 1");
   end

   dir_vec_t prod_mask;
   dir_vec_t pick;
   dir_vec_t sel_q;

   arsel_prod_mask #(.OFS_W(OFS_W)) u_mask (
      .dx   (dx),
      .dy   (dy),
      .mask (prod_mask)
   );

   arsel_pick #(.QLEN_W(QLEN_W), .TIE_X_WINS(TIE_X_WINS)) u_pick (
      .mask  (prod_mask),
      .wf_en (west_first_en),
      .q_py  (qlen_py),
      .q_px  (qlen_px),
      .q_my  (qlen_my),
      .q_mx  (qlen_mx),
      .pick  (pick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else begin
         sel_q <= req_valid ? pick : '0;
      end
   end

   assign sel_dir = sel_q;
endmodule

// File: rtl/arsel_chk.sv
module arsel_chk #(
   parameter int unsigned OFS_W      = 4,
   parameter int unsigned QLEN_W     = 4,
   parameter bit          TIE_X_WINS = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_valid,
   input logic signed [OFS_W-1:0] dx,
   input logic signed [OFS_W-1:0] dy,
   input logic                    west_first_en,
   input logic [QLEN_W-1:0]       qlen_py,
   input logic [QLEN_W-1:0]       qlen_px,
   input logic [QLEN_W-1:0]       qlen_my,
   input logic [QLEN_W-1:0]       qlen_mx,
   input logic [4:0]              sel_dir
);
   logic              both;
   logic              forced;
   logic [QLEN_W-1:0] cx;
   logic [QLEN_W-1:0] cy;
   logic [4:0]        xbit;
   logic [4:0]        ybit;

   assign both   = req_valid && (dx != 0) && (dy != 0);
   assign forced = west_first_en && (dx < 0);
   assign cx     = (dx > 0) ? qlen_px : qlen_mx;
   assign cy     = (dy > 0) ? qlen_py : qlen_my;
   assign xbit   = (dx > 0) ? 5'b00100 : 5'b10000;
   assign ybit   = (dy > 0) ? 5'b00010 : 5'b01000;

   p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> sel_dir == 5'b00000);

   p_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && dx == 0 && dy == 0 |=> sel_dir == 5'b00001);

   p_xzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && dx == 0 |=> !sel_dir[2] && !sel_dir[4]);

   p_yzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && dy == 0 |=> !sel_dir[1] && !sel_dir[3]);

   p_xsign_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && dx > 0 |=> !sel_dir[4]);

   p_ysign_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && dy < 0 |=> !sel_dir[1]);

   p_less_x_r6: assert property (@(posedge clk) disable iff (!rst_n)
      both && !forced && cx < cy |=> sel_dir == $past(xbit));

   p_less_y_r6: assert property (@(posedge clk) disable iff (!rst_n)
      both && !forced && cy < cx |=> sel_dir == $past(ybit));

   if (TIE_X_WINS) begin : g_tie
      p_tie_r7: assert property (@(posedge clk) disable iff (!rst_n)
         both && !forced && cx == cy |=> sel_dir == $past(xbit));
   end

   p_west_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && forced |=> sel_dir == 5'b10000);

   p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> $countones(sel_dir) == 1);
endmodule

bind adaptive_route_sel arsel_chk #(
   .OFS_W(OFS_W), .QLEN_W(QLEN_W), .TIE_X_WINS(TIE_X_WINS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .dx(dx), .dy(dy),
   .west_first_en(west_first_en), .qlen_py(qlen_py), .qlen_px(qlen_px),
   .qlen_my(qlen_my), .qlen_mx(qlen_mx), .sel_dir(sel_dir)
);

// File: tb/adaptive_route_sel_test.sv
module adaptive_route_sel_test;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic signed [3:0] dx = '0;
   logic signed [3:0] dy = '0;
   logic              west_first_en = 1'b0;
   logic [3:0]        qlen_py = '0;
   logic [3:0]        qlen_px = '0;
   logic [3:0]        qlen_my = '0;
   logic [3:0]        qlen_mx = '0;
   logic [4:0]        sel_dir;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   int    exp_v = 0;
   string exp_tag = "R2";

   always #2 clk = ~clk;

   adaptive_route_sel uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .dx(dx), .dy(dy),
      .west_first_en(west_first_en), .qlen_py(qlen_py), .qlen_px(qlen_px),
      .qlen_my(qlen_my), .qlen_mx(qlen_mx), .sel_dir(sel_dir)
   );

   // behavioural reference: port values 1=exit 2=+Y 4=+X 8=-Y 16=-X (R1)
   function automatic int ref_port(input bit v, input int x, input int y,
                                   input bit wf, input int qpy, input int qpx,
                                   input int qmy, input int qmx, output string tag);
      int qa, qb;
      if (!v) begin tag = "R3"; return 0; end
      if (x == 0 && y == 0) begin tag = "R4"; return 1; end
      if (x == 0) begin tag = "R5"; return (y > 0) ? 2 : 8; end
      if (y == 0) begin tag = "R5"; return (x > 0) ? 4 : 16; end
      if (wf && x < 0) begin tag = "R8"; return 16; end
      qa = (x > 0) ? qpx : qmx;
      qb = (y > 0) ? qpy : qmy;
      if (qa == qb) tag = "R7";
      else if (x < 0) tag = "R9";
      else tag = "R6";
      if (qa <= qb) return (x > 0) ? 4 : 16;
      return (y > 0) ? 2 : 8;
   endfunction

   task automatic compare();
      n_cmp++;
      if (int'(sel_dir) != exp_v) begin
         n_bad++;
         $display("FAIL %s R10 actual=%05b expected=%05b", exp_tag, sel_dir, 5'(exp_v));
      end
   endtask

   task automatic drive(input bit v, input int x, input int y, input bit wf,
                        input int qpy, input int qpx, input int qmy, input int qmx);
      string t;
      @(negedge clk);
      compare();
      req_valid = v; dx = 4'(x); dy = 4'(y); west_first_en = wf;
      qlen_py = 4'(qpy); qlen_px = 4'(qpx); qlen_my = 4'(qmy); qlen_mx = 4'(qmx);
      exp_v = ref_port(v, int'(dx), int'(dy), wf, qpy, qpx, qmy, qmx, t);
      exp_tag = t;
   endtask

   initial begin
      // R2: reset holds the output at zero even with a valid request present
      req_valid = 1'b1; dx = 4'sd3;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         compare();
      end
      rst_n = 1'b1;
      req_valid = 1'b0;
      exp_v = 0; exp_tag = "R2";
      // R4 exit, R3 idle
      drive(1, 0, 0, 0, 9, 9, 9, 9);
      drive(0, 3, 2, 0, 0, 0, 0, 0);
      drive(1, 0, 0, 1, 0, 0, 0, 0);
      // R5 single-axis cases, R1 bit order
      drive(1, 0, 5, 0, 15, 0, 0, 0);
      drive(1, 0, -4, 0, 0, 0, 15, 0);
      drive(1, 6, 0, 0, 0, 15, 0, 0);
      drive(1, -7, 0, 0, 0, 0, 0, 15);
      drive(1, -8, 0, 1, 0, 0, 0, 15);
      drive(1, 0, -8, 1, 0, 0, 0, 0);
      // R6 congestion choice
      drive(1, 2, 3, 0, 3, 8, 0, 0);
      drive(1, 2, 3, 0, 8, 3, 0, 0);
      drive(1, 2, -3, 1, 0, 9, 1, 0);
      drive(1, 7, -1, 0, 15, 14, 15, 0);
      // R7 tie goes to X
      drive(1, 1, 1, 0, 5, 5, 0, 0);
      drive(1, -1, -1, 0, 0, 0, 7, 7);
      drive(1, 3, -2, 1, 0, 0, 0, 0);
      // R8 west-first override vs R9 adaptive with the same traffic
      drive(1, -3, 2, 1, 1, 0, 0, 15);
      drive(1, -3, 2, 0, 1, 0, 0, 15);
      drive(1, -1, -5, 1, 0, 0, 0, 15);
      drive(1, -1, -5, 0, 0, 0, 0, 15);
      drive(1, -2, 4, 0, 9, 0, 0, 2);
      // mixed random traffic, both modes
      for (int i = 0; i < 3000; i++) begin
         drive(($urandom % 8) != 0, int'($signed(4'($urandom))), int'($signed(4'($urandom))),
               1'($urandom), int'($urandom % 16), int'($urandom % 16),
               int'($urandom % 16), int'($urandom % 16));
      end
      @(negedge clk);
      compare();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R2 watchdog actual=timeout expected=completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule